// File: doc/BRIEF.md
# Sponge AEAD Phase Sequencer

This block is the control state machine for a sponge-based authenticated cipher. After a command it sequences every phase of one encryption or decryption. First it loads the nonce and key into the state and runs the initial permutation. Next it absorbs the associated data and applies the domain-separation bit. It then encrypts or decrypts the message blocks. Last it runs the finalization permutation, extracts the tag and, on decrypt, checks the computed tag against the received one.

The state itself lives elsewhere. A rate-lane unit sees one registered pulse per operation on `lane_valid`, together with an opcode, a byte count and a pad flag. A permutation engine is driven by a `perm_start` pulse and a round count, and it answers with `perm_done`. The sequencer chooses the round count for each phase. It skips phases that have no data and never lets a decrypted message out unless the tag matched.

Top module: `aead_phase_seq`

## Requirements
- R1: After reset `busy`, `lane_valid`, `perm_start`, `done` and `release_pt` are 0 and `status` is 0x00.
- R2: The first lane operation of a command is init (opcode 1) and is followed by a permutation of INIT_ROUNDS (default 52) rounds. `lane_seal` is 1 on that init operation only when the state is 48 bytes with a 24-byte rate. Otherwise it is 0.
- R3: Associated data of zero length produces no absorb operation (opcode 2) and no permutation before the domain step.
- R4: Non-empty associated data produces one absorb of RATE_BYTES bytes with pad 0 for each full block. The remaining 0 to RATE_BYTES-1 bytes follow as one absorb with pad 1. Each absorb is followed by a permutation of MID_ROUNDS (default 28).
- R5: Exactly one domain operation (opcode 5) follows the associated-data phase, whether or not associated data was present.
- R6: Each full message block is an encrypt (opcode 3) or decrypt (opcode 4) operation of RATE_BYTES bytes, followed by a MID_ROUNDS permutation. The trailing padded block (pad 1, length 0 to RATE_BYTES-1) has no permutation after it. A zero-length message produces no message operation.
- R7: After the message phase come a permutation of FIN_ROUNDS (default 32) and then one tag-extract operation (opcode 6) whose length is TAG_BYTES.
- R8: `ct_len` equals the message length plus TAG_BYTES.
- R9: On decrypt a matching tag gives `status` 0x00 together with a `release_pt` pulse alongside `done`. Any single differing byte gives `status` 0xFF and no `release_pt`. Encrypt always reports 0x00 without `release_pt`.
- R10: The number of cycles from the tag-extract operation to `done` is the same whether the tags match or differ, and whichever byte differs.
- R11: While `busy` is 1, `cmd_start` is ignored. The running command's operation sequence and `ct_len` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start a command (only while idle) |
| cmd_decrypt | input | 1 | 1 = decrypt, 0 = encrypt |
| cmd_ad_len | input | LEN_W | Associated-data length in bytes |
| cmd_msg_len | input | LEN_W | Message length in bytes |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| status | output | 8 | 0x00 ok, 0xFF tag mismatch; valid with done |
| release_pt | output | 1 | Plaintext may be released; pulses with done |
| ct_len | output | LEN_W | Message length plus tag length |
| lane_valid | output | 1 | One-cycle lane operation pulse |
| lane_op | output | 3 | 1 init, 2 absorb, 3 encrypt, 4 decrypt, 5 domain, 6 tag extract |
| lane_len | output | LANE_W | Bytes of data in the operation |
| lane_pad | output | 1 | Append the pad byte after lane_len bytes |
| lane_seal | output | 1 | Init: set last state byte to 0x80 |
| perm_start | output | 1 | One-cycle permutation start pulse |
| perm_rounds | output | RND_W | Round count for the permutation |
| perm_done | input | 1 | Permutation finished |
| tag_calc | input | TAG_BYTES*8 | Tag extracted from the state, byte 0 in bits 7:0 |
| tag_rx | input | TAG_BYTES*8 | Received tag, same byte order |

## Verification
The hardest case to reach is a length that is an exact multiple of the rate. The last full block must still be followed by an empty padded block. For associated data that block gets a permutation, but for the message it does not. The vector table includes lengths 0, 8, 16 and 20 for both fields, and the bench checks the full logged operation sequence against one it builds from the rules. Mismatches are placed at the first and at the last tag byte, and the tag-to-done latency is compared across them. A second start is injected in the middle of a run.

// File: rtl/aead_seq_pkg.sv
package aead_seq_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_INIT   = 3'd1,
    OP_ABSORB = 3'd2,
    OP_ENC    = 3'd3,
    OP_DEC    = 3'd4,
    OP_DOMAIN = 3'd5,
    OP_TAG    = 3'd6
  } lane_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_AD, S_DOM, S_MSG, S_FIN,
    S_TAG, S_CMP, S_PSTART, S_PWAIT, S_DONE
  } seq_state_e;
endpackage

// File: rtl/aead_len_track.sv
module aead_len_track #(
  parameter int LEN_W = 16,
  parameter int STEP  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             step,
  output logic [LEN_W-1:0] rem,
  output logic             has_full
);
  localparam logic [LEN_W-1:0] STEP_V = LEN_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst)       rem <= '0;
    else if (load) rem <= load_val;
    else if (step) rem <= rem - STEP_V;
  end

  assign has_full = (rem >= STEP_V);

  // R4
  step_full_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> has_full);
endmodule

// File: rtl/aead_tag_cmp.sv
module aead_tag_cmp #(
  parameter int TAG_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   go,
  input  logic [TAG_BYTES*8-1:0] tag_a,
  input  logic [TAG_BYTES*8-1:0] tag_b,
  output logic                   fin,
  output logic                   mism
);
  localparam int IW = (TAG_BYTES > 1) ? $clog2(TAG_BYTES) : 1;
  localparam logic [IW-1:0] LAST = IW'(TAG_BYTES - 1);

  logic          active;
  logic [IW-1:0] idx;
  logic [7:0]    acc;
  logic [7:0]    diff;

  assign diff = tag_a[idx*8 +: 8] ^ tag_b[idx*8 +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      acc    <= '0;
      fin    <= 1'b0;
      mism   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        active <= 1'b1;
        idx    <= '0;
        acc    <= '0;
      end else if (active) begin
        acc <= acc | diff;
        idx <= idx + 1'b1;
        if (idx == LAST) begin
          active <= 1'b0;
          fin    <= 1'b1;
          mism   <= |(acc | diff);
        end
      end
    end
  end

  // R10
  cmp_span_chk: assert property (@(posedge clk) disable iff (rst)
    (active && idx != LAST) |=> (active && !fin));
endmodule

// File: rtl/aead_phase_seq.sv
module aead_phase_seq
  import aead_seq_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int RATE_BYTES  = 8,
  parameter int TAG_BYTES   = 16,
  parameter int STATE_BYTES = 32,
  parameter int RND_W       = 8,
  parameter int INIT_ROUNDS = 52,
  parameter int MID_ROUNDS  = 28,
  parameter int FIN_ROUNDS  = 32,
  parameter int LANE_W      = $clog2(((RATE_BYTES > TAG_BYTES) ? RATE_BYTES : TAG_BYTES) + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_start,
  input  logic                   cmd_decrypt,
  input  logic [LEN_W-1:0]       cmd_ad_len,
  input  logic [LEN_W-1:0]       cmd_msg_len,
  output logic                   busy,
  output logic                   done,
  output logic [7:0]             status,
  output logic                   release_pt,
  output logic [LEN_W-1:0]       ct_len,
  output logic                   lane_valid,
  output logic [2:0]             lane_op,
  output logic [LANE_W-1:0]      lane_len,
  output logic                   lane_pad,
  output logic                   lane_seal,
  output logic                   perm_start,
  output logic [RND_W-1:0]       perm_rounds,
  input  logic                   perm_done,
  input  logic [TAG_BYTES*8-1:0] tag_calc,
  input  logic [TAG_BYTES*8-1:0] tag_rx
);
  localparam logic SEAL_CFG = (STATE_BYTES == 48) && (RATE_BYTES == 24);
  localparam logic [LANE_W-1:0] RATE_L = LANE_W'(RATE_BYTES);
  localparam logic [LANE_W-1:0] TAG_L  = LANE_W'(TAG_BYTES);
  localparam logic [LEN_W-1:0]  TAG_N  = LEN_W'(TAG_BYTES);

  seq_state_e       state, ret_state;
  logic [RND_W-1:0] pend_rounds;
  logic             is_dec, ad_zero, msg_zero;
  logic             cmp_go, cmp_fin, cmp_mism;
  logic [LEN_W-1:0] ad_rem, msg_rem;
  logic             ad_full, msg_full;
  logic             take;

  assign take = cmd_start && (state == S_IDLE);

  aead_len_track #(.LEN_W(LEN_W), .STEP(RATE_BYTES)) u_ad_trk (
    .clk(clk), .rst(rst), .load(take), .load_val(cmd_ad_len),
    .step(state == S_AD && ad_full), .rem(ad_rem), .has_full(ad_full));

  aead_len_track #(.LEN_W(LEN_W), .STEP(RATE_BYTES)) u_msg_trk (
    .clk(clk), .rst(rst), .load(take), .load_val(cmd_msg_len),
    .step(state == S_MSG && msg_full), .rem(msg_rem), .has_full(msg_full));

  aead_tag_cmp #(.TAG_BYTES(TAG_BYTES)) u_cmp (
    .clk(clk), .rst(rst), .go(cmp_go), .tag_a(tag_calc), .tag_b(tag_rx),
    .fin(cmp_fin), .mism(cmp_mism));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      ret_state   <= S_IDLE;
      pend_rounds <= '0;
      is_dec      <= 1'b0;
      ad_zero     <= 1'b0;
      msg_zero    <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      status      <= 8'h00;
      release_pt  <= 1'b0;
      ct_len      <= '0;
      lane_valid  <= 1'b0;
      lane_op     <= OP_NONE;
      lane_len    <= '0;
      lane_pad    <= 1'b0;
      lane_seal   <= 1'b0;
      perm_start  <= 1'b0;
      perm_rounds <= '0;
      cmp_go      <= 1'b0;
    end else begin
      lane_valid <= 1'b0;
      lane_seal  <= 1'b0;
      perm_start <= 1'b0;
      done       <= 1'b0;
      release_pt <= 1'b0;
      cmp_go     <= 1'b0;
      unique case (state)
        S_IDLE: if (cmd_start) begin
          is_dec   <= cmd_decrypt;
          ad_zero  <= (cmd_ad_len == '0);
          msg_zero <= (cmd_msg_len == '0);
          ct_len   <= cmd_msg_len + TAG_N;
          busy     <= 1'b1;
          state    <= S_INIT;
        end
        S_INIT: begin
          lane_valid  <= 1'b1;
          lane_op     <= OP_INIT;
          lane_len    <= '0;
          lane_pad    <= 1'b0;
          lane_seal   <= SEAL_CFG;
          pend_rounds <= RND_W'(INIT_ROUNDS);
          ret_state   <= ad_zero ? S_DOM : S_AD;
          state       <= S_PSTART;
        end
        S_AD: begin
          lane_valid  <= 1'b1;
          lane_op     <= OP_ABSORB;
          lane_len    <= ad_full ? RATE_L : LANE_W'(ad_rem);
          lane_pad    <= !ad_full;
          pend_rounds <= RND_W'(MID_ROUNDS);
          ret_state   <= ad_full ? S_AD : S_DOM;
          state       <= S_PSTART;
        end
        S_DOM: begin
          lane_valid <= 1'b1;
          lane_op    <= OP_DOMAIN;
          lane_len   <= '0;
          lane_pad   <= 1'b0;
          state      <= msg_zero ? S_FIN : S_MSG;
        end
        S_MSG: begin
          lane_valid  <= 1'b1;
          lane_op     <= is_dec ? OP_DEC : OP_ENC;
          lane_len    <= msg_full ? RATE_L : LANE_W'(msg_rem);
          lane_pad    <= !msg_full;
          pend_rounds <= RND_W'(MID_ROUNDS);
          ret_state   <= S_MSG;
          state       <= msg_full ? S_PSTART : S_FIN;
        end
        S_FIN: begin
          pend_rounds <= RND_W'(FIN_ROUNDS);
          ret_state   <= S_TAG;
          state       <= S_PSTART;
        end
        S_TAG: begin
          lane_valid <= 1'b1;
          lane_op    <= OP_TAG;
          lane_len   <= TAG_L;
          lane_pad   <= 1'b0;
          cmp_go     <= is_dec;
          state      <= is_dec ? S_CMP : S_DONE;
        end
        S_CMP: if (cmp_fin) state <= S_DONE;
        S_PSTART: begin
          perm_start  <= 1'b1;
          perm_rounds <= pend_rounds;
          state       <= S_PWAIT;
        end
        S_PWAIT: if (perm_done) state <= ret_state;
        S_DONE: begin
          done       <= 1'b1;
          busy       <= 1'b0;
          status     <= (is_dec && cmp_mism) ? 8'hFF : 8'h00;
          release_pt <= is_dec && !cmp_mism;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  release_ok_chk: assert property (@(posedge clk) disable iff (rst)
    release_pt |-> (done && status == 8'h00));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!lane_valid && !perm_start));

  // R7
  perm_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    perm_start |=> (!perm_start && $stable(perm_rounds)));

  // R4
  lane_len_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_valid && lane_op != OP_TAG) |-> (lane_len <= RATE_L));

  // R6
  pad_no_perm_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_valid && lane_pad && (lane_op == OP_ENC || lane_op == OP_DEC)) |=> !perm_start);

  // R8
  ctlen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ct_len));
endmodule

// File: tb/aead_phase_seq_bench.sv
module aead_phase_seq_bench;
  localparam int LEN_W = 16;
  localparam int RATE  = 8;
  localparam int TAGB  = 16;
  localparam int LW    = $clog2(TAGB + 1);
  localparam int NV    = 10;
  localparam int PERM_OP = 7;

  // {ad_len, msg_len, decrypt, err_pos (255 = none)}
  localparam int VEC [NV][4] = '{
    '{0, 0, 0, 255}, '{3, 5, 0, 255}, '{8, 8, 0, 255}, '{16, 20, 1, 255},
    '{0, 13, 1, 0},  '{20, 0, 1, 15}, '{7, 16, 1, 255}, '{9, 1, 1, 7},
    '{0, 8, 1, 255}, '{17, 3, 0, 255}};

  logic clk = 0, rst = 1;
  logic cmd_start = 0, cmd_decrypt = 0;
  logic [LEN_W-1:0] cmd_ad_len = 0, cmd_msg_len = 0;
  logic busy, done, release_pt, lane_valid, lane_pad, lane_seal, perm_start;
  logic [7:0] status, perm_rounds;
  logic [LEN_W-1:0] ct_len;
  logic [2:0] lane_op;
  logic [LW-1:0] lane_len;
  logic perm_done = 0;
  logic [TAGB*8-1:0] tag_calc = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
  logic [TAGB*8-1:0] tag_rx;

  always #4 clk = ~clk;

  aead_phase_seq u_aead_phase_seq (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_decrypt(cmd_decrypt),
    .cmd_ad_len(cmd_ad_len), .cmd_msg_len(cmd_msg_len), .busy(busy), .done(done),
    .status(status), .release_pt(release_pt), .ct_len(ct_len),
    .lane_valid(lane_valid), .lane_op(lane_op), .lane_len(lane_len),
    .lane_pad(lane_pad), .lane_seal(lane_seal), .perm_start(perm_start),
    .perm_rounds(perm_rounds), .perm_done(perm_done),
    .tag_calc(tag_calc), .tag_rx(tag_rx));

  // second configuration: 48-byte state, 24-byte rate
  logic a_start = 0, a_busy, a_done, a_rel, a_lv, a_pad, a_seal, a_ps;
  logic [7:0] a_status, a_rounds;
  logic [LEN_W-1:0] a_ct;
  logic [2:0] a_op;
  logic [$clog2(25)-1:0] a_len;
  aead_phase_seq #(.STATE_BYTES(48), .RATE_BYTES(24)) u_alt (
    .clk(clk), .rst(rst), .cmd_start(a_start), .cmd_decrypt(1'b0),
    .cmd_ad_len(16'd0), .cmd_msg_len(16'd0), .busy(a_busy), .done(a_done),
    .status(a_status), .release_pt(a_rel), .ct_len(a_ct),
    .lane_valid(a_lv), .lane_op(a_op), .lane_len(a_len), .lane_pad(a_pad),
    .lane_seal(a_seal), .perm_start(a_ps), .perm_rounds(a_rounds),
    .perm_done(1'b1), .tag_calc(tag_calc), .tag_rx(tag_calc));

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int ev [64];
  int ev_n = 0;
  int xp [64];
  int xp_n = 0;
  int t_tag = 0, t_done = 0;
  logic got_done = 0, got_rel = 0;
  logic [7:0] got_status = 0;
  logic [LEN_W-1:0] got_ct = 0;
  int pcnt = 0;
  int alt_seal = -1;

  // event log, permutation stub and output capture, all away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (lane_valid && ev_n < 64) begin
      ev[ev_n] = int'(lane_op) * 65536 + int'(lane_seal) * 4096 + int'(lane_pad) * 256 + int'(lane_len);
      ev_n++;
      if (lane_op == 3'd6) t_tag = cyc;
    end
    if (perm_start && ev_n < 64) begin
      ev[ev_n] = PERM_OP * 65536 + int'(perm_rounds);
      ev_n++;
    end
    perm_done = 0;
    if (perm_start) pcnt = 4;
    else if (pcnt > 0) begin
      pcnt--;
      if (pcnt == 0) perm_done = 1;
    end
    if (done) begin
      got_done = 1; got_status = status; got_rel = release_pt; got_ct = ct_len; t_done = cyc;
    end
    if (a_lv && a_op == 3'd1) alt_seal = int'(a_seal);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int v);
    xp[xp_n] = v; xp_n++;
  endtask

  task automatic build(input int ad, input int msg, input int dec);
    int r;
    xp_n = 0;
    push(1 * 65536);                        // R2 init, no seal
    push(PERM_OP * 65536 + 52);
    if (ad > 0) begin                       // R3, R4
      r = ad;
      while (r >= RATE) begin
        push(2 * 65536 + RATE); push(PERM_OP * 65536 + 28); r -= RATE;
      end
      push(2 * 65536 + 256 + r); push(PERM_OP * 65536 + 28);
    end
    push(5 * 65536);                        // R5
    if (msg > 0) begin                      // R6
      r = msg;
      while (r >= RATE) begin
        push((dec ? 4 : 3) * 65536 + RATE); push(PERM_OP * 65536 + 28); r -= RATE;
      end
      push((dec ? 4 : 3) * 65536 + 256 + r);
    end
    push(PERM_OP * 65536 + 32);             // R7
    push(6 * 65536 + TAGB);
  endtask

  task automatic launch(input int ad, input int msg, input int dec, input int ep);
    tag_rx = tag_calc;
    if (ep != 255) tag_rx[ep*8 +: 8] = tag_calc[ep*8 +: 8] ^ 8'h40;
    @(negedge clk);
    ev_n = 0; got_done = 0;
    cmd_ad_len = LEN_W'(ad); cmd_msg_len = LEN_W'(msg); cmd_decrypt = dec[0];
    cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic finish_and_check(input int ad, input int msg, input int dec, input int ep);
    int w;
    bit same;
    w = 0;
    while (!got_done && w < 2000) begin @(negedge clk); w++; end
    check(got_done, "R11 done reached", int'(got_done), 1);
    build(ad, msg, dec);
    same = (ev_n == xp_n);
    for (int i = 0; i < xp_n && same; i++) if (ev[i] != xp[i]) same = 0;
    check(same, "R2 R3 R4 R5 R6 R7 operation sequence", ev_n, xp_n);
    for (int i = 0; i < xp_n && i < ev_n; i++)
      if (ev[i] != xp[i]) begin
        $display("  at %0d: got %h exp %h", i, ev[i], xp[i]);
        break;
      end
    check(got_ct == LEN_W'(msg + TAGB), "R8 ct_len", int'(got_ct), msg + TAGB);
    check(got_status == ((dec == 1 && ep != 255) ? 8'hFF : 8'h00), "R9 status",
          int'(got_status), (dec == 1 && ep != 255) ? 255 : 0);
    check(got_rel == (dec == 1 && ep == 255), "R9 release_pt",
          int'(got_rel), int'(dec == 1 && ep == 255));
  endtask

  int ref_lat = -1;

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !lane_valid && !perm_start && !done && !release_pt && status == 8'h00,
          "R1 reset outputs", int'(busy), 0);
    rst = 0;
    @(negedge clk);
    check(!busy && !lane_valid && !perm_start, "R1 after reset release", int'(busy), 0);

    for (int v = 0; v < NV; v++) begin
      launch(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      finish_and_check(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      if (VEC[v][2] == 1) begin
        // R10 constant compare latency
        if (ref_lat < 0) ref_lat = t_done - t_tag;
        check((t_done - t_tag) == ref_lat, "R10 tag-to-done latency", t_done - t_tag, ref_lat);
      end
    end

    // R11 start while busy ignored
    launch(5, 9, 0, 255);
    repeat (6) @(negedge clk);
    cmd_ad_len = 16'd30; cmd_msg_len = 16'd2; cmd_decrypt = 1; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    finish_and_check(5, 9, 0, 255);
    repeat (5) @(negedge clk);
    check(!busy, "R11 idle after run", int'(busy), 0);

    // R2 seal flag in the 48/24 configuration
    @(negedge clk); a_start = 1; @(negedge clk); a_start = 0;
    repeat (40) @(negedge clk);
    check(alt_seal == 1, "R2 seal in 48-byte state", alt_seal, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule